// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates a virtual address into a physical address through a fully associative table of entries. Every entry covers a pair of adjacent pages, an even one and an odd one, and its page size is chosen per entry by a page-size field. Software-side logic loads entries through an indexed write port. The memory pipeline presents a lookup request with a virtual address, the current address-space identifier and a read/write flag. One cycle later the block returns either a physical address with a permission level, or an exception code. An exception response carries a refill flag, the faulting address, its pair number and the identifier that was used.

All entries are compared in parallel. When several entries match, the lowest index decides. A matching entry can still refuse the access: a clear valid bit in the chosen half gives an invalid fault, and a write to a clean page gives a modify fault. A request that matches nothing gives a refill fault.

Top module: `tlb_pair_lookup`

## Requirements
- R1: Reset clears every entry word to zero and drives rsp_valid, rsp_hit and rsp_refill low and rsp_exc to 0. A lookup after reset therefore sees all-zero entries.
- R2: When wr_en is high, entry wr_idx takes wr_pgmask, wr_hi, wr_lo0 and wr_lo1 at the clock edge. The new contents are seen by lookups from the next cycle on.
- R3: The page shift of an entry is 12, 14, 16, 18, 20, 22, 24 or 26 when wr_pgmask (address-mask bits 26:13) is 0x0, 0x3, 0xF, 0x3F, 0xFF, 0x3FF, 0xFFF or 0x3FFF. Any other value gives a shift of 12.
- R4: An entry matches when the virtual address and EntryHi agree on every bit from pageshift+1 up to bit 39. In addition, either EntryHi[7:0] must equal req_asid or EntryHi bit 12 (global) must be set.
- R5: Virtual-address bit [pageshift] selects the half: 1 selects EntryLo1 and 0 selects EntryLo0. Within an EntryLo word, V is bit 1, D is bit 2 and the PFN is bits 29:6.
- R6: A hit gives rsp_hit=1 and rsp_exc=0. It also gives rsp_paddr = (PFN << 12) | (vaddr & ((1<<pageshift)-1)), and rsp_level=2 when D is set or 1 when D is clear.
- R7: When no entry matches, the response is rsp_refill=1, with rsp_exc=2 for a read or 3 for a write.
- R8: A match whose selected V bit is clear gives rsp_refill=0, with rsp_exc=2 for a read or 3 for a write.
- R9: A write to a valid page with D clear gives rsp_exc=1 and rsp_refill=0. A read of the same page is a hit with level 1.
- R10: Every response reports the request's virtual address on rsp_vaddr, its bits 39:13 on rsp_vpn2, and req_asid on rsp_asid.
- R11: When more than one entry matches, the entry with the lowest index supplies the result.
- R12: rsp_valid is high exactly in the cycle after a cycle with req_valid high. Back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_pgmask | input | 14 | Page-size field (address-mask bits 26:13) |
| wr_hi | input | 40 | EntryHi: pair number 39:13, global 12, ASID 7:0 |
| wr_lo0 | input | 32 | EntryLo for the even page |
| wr_lo1 | input | 32 | EntryLo for the odd page |
| req_valid | input | 1 | Lookup request |
| req_va | input | 40 | Virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | 1 for a store access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_level | output | 2 | 2 read/write, 1 read-only, 0 on fault |
| rsp_paddr | output | 36 | Physical address on a hit |
| rsp_exc | output | 3 | 0 none, 1 modify, 2 load fault, 3 store fault |
| rsp_refill | output | 1 | Fault caused by a missing entry |
| rsp_vaddr | output | 40 | Faulting or translated virtual address |
| rsp_vpn2 | output | 27 | Pair number of the virtual address |
| rsp_asid | output | 8 | Identifier used for the lookup |

## Verification
The assertions assume that a write and a lookup never share a cycle. They also assume that req_write and req_asid are only meaningful while req_valid is high, so the modify check compares against the write flag of the cycle that carried the request. The stimulus keeps the write port and the lookup port in separate cycles. It loads entries whose page pairs are aligned to the pair size and sends lookups only at whole-cycle boundaries, so every response comes from a table state that the reference model also holds.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // EntryLo layout
  localparam int LO_W       = 32;
  localparam int LO_V_BIT   = 1;
  localparam int LO_D_BIT   = 2;
  localparam int LO_PFN_LSB = 6;
  localparam int PFN_W      = 24;
  // EntryHi layout
  localparam int HI_G_BIT   = 12;
  localparam int ASID_W     = 8;
  // page geometry
  localparam int MIN_SHIFT  = 12;
  localparam int PAIR_LSB   = 13;
  localparam int MASK_W     = 14;
  localparam int SHIFT_W    = 5;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_MOD  = 3'd1,
    EXC_TLBL = 3'd2,
    EXC_TLBS = 3'd3
  } tlb_exc_e;

  // Legal fields are runs of ones of even length; anything else falls to 4 KB.
  function automatic logic [SHIFT_W-1:0] decode_shift(input logic [MASK_W-1:0] fld);
    logic [SHIFT_W-1:0] s;
    s = SHIFT_W'(MIN_SHIFT);
    for (int k = 1; k <= MASK_W/2; k++) begin
      if (fld == MASK_W'((1 << (2*k)) - 1)) s = SHIFT_W'(MIN_SHIFT + 2*k);
    end
    return s;
  endfunction
endpackage

// File: rtl/tlb_pagesize_dec.sv
module tlb_pagesize_dec
  import tlb_pkg::*;
(
  input  logic [MASK_W-1:0]  mask_fld,
  output logic [SHIFT_W-1:0] page_shift
);
  always_comb begin
    page_shift = decode_shift(mask_fld);
  end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
#(
  parameter int VA_W = 40,
  parameter int PA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_pgmask,
  input  logic [VA_W-1:0]   wr_hi,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              match,
  output logic [LO_W-1:0]   sel_lo,
  output logic [PA_W-1:0]   sel_off
);
  logic [MASK_W-1:0]  mask_q;
  logic [VA_W-1:0]    hi_q;
  logic [LO_W-1:0]    lo0_q, lo1_q;
  logic [SHIFT_W-1:0] pshift;
  logic [VA_W-1:0]    vpn_mask, off_mask, off_full;
  logic               vpn_eq, asid_eq, odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      hi_q   <= '0;
      lo0_q  <= '0;
      lo1_q  <= '0;
    end else if (wr_en) begin
      mask_q <= wr_pgmask;
      hi_q   <= wr_hi;
      lo0_q  <= wr_lo0;
      lo1_q  <= wr_lo1;
    end
  end

  tlb_pagesize_dec i_dec (
    .mask_fld   (mask_q),
    .page_shift (pshift)
  );

  always_comb begin
    vpn_mask = {VA_W{1'b1}} << (pshift + SHIFT_W'(1));
    off_mask = ~({VA_W{1'b1}} << pshift);
    vpn_eq   = ((lk_va ^ hi_q) & vpn_mask) == '0;
    asid_eq  = hi_q[ASID_W-1:0] == lk_asid;
    match    = vpn_eq && (asid_eq || hi_q[HI_G_BIT]);
    odd      = lk_va[pshift];
    sel_lo   = odd ? lo1_q : lo0_q;
    off_full = lk_va & off_mask;
    sel_off  = off_full[PA_W-1:0];
  end

  // R2
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hi_q == $past(wr_hi) && lo0_q == $past(wr_lo0) &&
               lo1_q == $past(wr_lo1) && mask_q == $past(wr_pgmask)));
endmodule

// File: rtl/tlb_first_sel.sv
module tlb_first_sel #(
  parameter int N = 48
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = req & (~req + N'(1));
    any = |req;
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 48,
  parameter int VA_W      = 40,
  parameter int IDX_W     = $clog2(N_ENTRIES),
  parameter int PA_W      = PFN_W + MIN_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [MASK_W-1:0]    wr_pgmask,
  input  logic [VA_W-1:0]      wr_hi,
  input  logic [LO_W-1:0]      wr_lo0,
  input  logic [LO_W-1:0]      wr_lo1,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic                 req_write,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [1:0]           rsp_level,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic [2:0]           rsp_exc,
  output logic                 rsp_refill,
  output logic [VA_W-1:0]      rsp_vaddr,
  output logic [VA_W-PAIR_LSB-1:0] rsp_vpn2,
  output logic [ASID_W-1:0]    rsp_asid
);
  localparam int VPN_W = VA_W - PAIR_LSB;

  logic [N_ENTRIES-1:0] slot_we, slot_match, gnt;
  logic                 any_match;
  logic [LO_W-1:0]      slot_lo  [N_ENTRIES];
  logic [PA_W-1:0]      slot_off [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
    tlb_slot #(.VA_W(VA_W), .PA_W(PA_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (slot_we[g]),
      .wr_pgmask (wr_pgmask),
      .wr_hi     (wr_hi),
      .wr_lo0    (wr_lo0),
      .wr_lo1    (wr_lo1),
      .lk_va     (req_va),
      .lk_asid   (req_asid),
      .match     (slot_match[g]),
      .sel_lo    (slot_lo[g]),
      .sel_off   (slot_off[g])
    );
  end

  tlb_first_sel #(.N(N_ENTRIES)) i_sel (
    .req (slot_match),
    .gnt (gnt),
    .any (any_match)
  );

  // merge of the winning slot
  logic [LO_W-1:0] lo_m;
  logic [PA_W-1:0] off_m;
  always_comb begin
    lo_m  = '0;
    off_m = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      lo_m  = lo_m  | (slot_lo[i]  & {LO_W{gnt[i]}});
      off_m = off_m | (slot_off[i] & {PA_W{gnt[i]}});
    end
  end

  logic             pg_v, pg_d;
  logic [PFN_W-1:0] pg_pfn;
  logic             unused_lo_bits;
  assign pg_v   = lo_m[LO_V_BIT];
  assign pg_d   = lo_m[LO_D_BIT];
  assign pg_pfn = lo_m[LO_PFN_LSB +: PFN_W];
  assign unused_lo_bits = ^{lo_m[LO_W-1:LO_PFN_LSB+PFN_W], lo_m[LO_PFN_LSB-1:LO_D_BIT+1], lo_m[0]};

  // outcome next-state
  logic            hit_d, refill_d;
  logic [1:0]      level_d;
  logic [PA_W-1:0] paddr_d;
  tlb_exc_e        exc_d;
  always_comb begin
    hit_d    = 1'b0;
    refill_d = 1'b0;
    level_d  = 2'd0;
    paddr_d  = '0;
    exc_d    = EXC_NONE;
    if (!any_match) begin
      refill_d = 1'b1;
      exc_d    = req_write ? EXC_TLBS : EXC_TLBL;
    end else if (!pg_v) begin
      exc_d    = req_write ? EXC_TLBS : EXC_TLBL;
    end else if (req_write && !pg_d) begin
      exc_d    = EXC_MOD;
    end else begin
      hit_d    = 1'b1;
      level_d  = pg_d ? 2'd2 : 2'd1;
      paddr_d  = {pg_pfn, {MIN_SHIFT{1'b0}}} | off_m;
    end
  end

  // response registers
  logic             vld_q, hit_q, refill_q;
  logic [1:0]       level_q;
  logic [PA_W-1:0]  paddr_q;
  tlb_exc_e         exc_q;
  logic [VA_W-1:0]  va_q;
  logic [ASID_W-1:0] asid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      refill_q <= 1'b0;
      level_q  <= 2'd0;
      paddr_q  <= '0;
      exc_q    <= EXC_NONE;
      va_q     <= '0;
      asid_q   <= '0;
    end else if (req_valid) begin
      hit_q    <= hit_d;
      refill_q <= refill_d;
      level_q  <= level_d;
      paddr_q  <= paddr_d;
      exc_q    <= exc_d;
      va_q     <= req_va;
      asid_q   <= req_asid;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_hit    = hit_q;
  assign rsp_refill = refill_q;
  assign rsp_level  = level_q;
  assign rsp_paddr  = paddr_q;
  assign rsp_exc    = exc_q;
  assign rsp_vaddr  = va_q;
  assign rsp_vpn2   = va_q[VA_W-1:PAIR_LSB];
  assign rsp_asid   = asid_q;

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  mod_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == EXC_MOD) |-> $past(req_write));
  // R7
  refill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_refill) |-> (!rsp_hit && (rsp_exc == EXC_TLBL || rsp_exc == EXC_TLBS)));
  // R6
  hit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_exc == EXC_NONE && rsp_level != 2'd0 && !rsp_refill));
  // R10
  fault_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_asid == $past(req_asid) && rsp_vaddr == $past(req_va)));
  // R8
  store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == EXC_TLBS) |-> $past(req_write));
endmodule

// File: tb/test_tlb_pair_lookup.sv
module test_tlb_pair_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 48;
  localparam int VA_W = 40;
  localparam int PA_W = 36;
  localparam int IW   = 6;

  logic clk, rst_n;
  logic wr_en;
  logic [IW-1:0] wr_idx;
  logic [13:0] wr_pgmask;
  logic [VA_W-1:0] wr_hi;
  logic [31:0] wr_lo0, wr_lo1;
  logic req_valid, req_write;
  logic [VA_W-1:0] req_va;
  logic [7:0] req_asid;
  logic rsp_valid, rsp_hit, rsp_refill;
  logic [1:0] rsp_level;
  logic [PA_W-1:0] rsp_paddr;
  logic [2:0] rsp_exc;
  logic [VA_W-1:0] rsp_vaddr;
  logic [VA_W-14:0] rsp_vpn2;
  logic [7:0] rsp_asid;

  tlb_pair_lookup i_tlb_pair_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pgmask(wr_pgmask),
    .wr_hi(wr_hi), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .req_valid(req_valid),
    .req_va(req_va), .req_asid(req_asid), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_level(rsp_level), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc),
    .rsp_refill(rsp_refill), .rsp_vaddr(rsp_vaddr), .rsp_vpn2(rsp_vpn2), .rsp_asid(rsp_asid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic hit; logic [1:0] level; logic [PA_W-1:0] paddr; logic [2:0] exc;
    logic refill; logic [VA_W-1:0] va; logic [7:0] asid; string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [13:0]     m_mask [N];
  logic [VA_W-1:0] m_hi   [N];
  logic [31:0]     m_lo0  [N];
  logic [31:0]     m_lo1  [N];

  function automatic int bshift(logic [13:0] m);
    case (m)
      14'h0000: return 12;  14'h0003: return 14;  14'h000F: return 16;
      14'h003F: return 18;  14'h00FF: return 20;  14'h03FF: return 22;
      14'h0FFF: return 24;  14'h3FFF: return 26;
      default:  return 12;
    endcase
  endfunction

  function automatic exp_t predict(logic [VA_W-1:0] va, logic [7:0] asid, logic wr, string tag);
    exp_t e;
    bit found = 0;
    e.hit = 0; e.level = 0; e.paddr = '0; e.exc = 3'd0; e.refill = 0;
    e.va = va; e.asid = asid; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      int ps;
      logic [31:0] lo;
      ps = bshift(m_mask[i]);
      if (!found && ((va >> (ps+1)) == (m_hi[i] >> (ps+1))) &&
          (m_hi[i][7:0] == asid || m_hi[i][12])) begin
        found = 1;
        lo = va[ps] ? m_lo1[i] : m_lo0[i];
        if (!lo[1])                e.exc = wr ? 3'd3 : 3'd2;
        else if (wr && !lo[2])     e.exc = 3'd1;
        else begin
          e.hit = 1;
          e.level = lo[2] ? 2'd2 : 2'd1;
          e.paddr = PA_W'({lo[29:6], 12'h000}) | PA_W'(va & ((40'd1 << ps) - 40'd1));
        end
      end
    end
    if (!found) begin
      e.refill = 1;
      e.exc = wr ? 3'd3 : 3'd2;
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic write_entry(int idx, logic [13:0] mk, logic [VA_W-1:0] hi, logic [31:0] l0, logic [31:0] l1);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = IW'(idx); wr_pgmask = mk; wr_hi = hi; wr_lo0 = l0; wr_lo1 = l1;
    m_mask[idx] = mk; m_hi[idx] = hi; m_lo0[idx] = l0; m_lo1[idx] = l1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(logic [VA_W-1:0] va, logic [7:0] asid, logic wr, string tag);
    @(negedge clk);
    wr_en = 0;
    req_valid = 1; req_va = va; req_asid = asid; req_write = wr;
    q.push_back(predict(va, asid, wr, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R12", "response without request");
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_hit === e.hit && rsp_level === e.level && rsp_paddr === e.paddr &&
              rsp_exc === e.exc && rsp_refill === e.refill && rsp_vaddr === e.va &&
              rsp_vpn2 === e.va[VA_W-1:13] && rsp_asid === e.asid, e.tag,
              $sformatf("va=%h got hit=%0d lvl=%0d pa=%h exc=%0d rf=%0d vpn2=%h asid=%h exp hit=%0d lvl=%0d pa=%h exc=%0d rf=%0d vpn2=%h asid=%h",
                        e.va, rsp_hit, rsp_level, rsp_paddr, rsp_exc, rsp_refill, rsp_vpn2, rsp_asid,
                        e.hit, e.level, e.paddr, e.exc, e.refill, e.va[VA_W-1:13], e.asid));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    logic [VA_W-1:0] bases [8];
    logic [7:0] asids [4];
    for (int i = 0; i < N; i++) begin
      m_mask[i] = '0; m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    rst_n = 0; wr_en = 0; wr_idx = '0; wr_pgmask = '0; wr_hi = '0; wr_lo0 = '0; wr_lo1 = '0;
    req_valid = 0; req_va = '0; req_asid = '0; req_write = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid === 0 && rsp_hit === 0 && rsp_refill === 0 && rsp_exc === 3'd0, "R1",
        $sformatf("valid=%0d hit=%0d rf=%0d exc=%0d exp 0 0 0 0", rsp_valid, rsp_hit, rsp_refill, rsp_exc));
    rst_n = 1;
    @(negedge clk);
    // R1: zero entries match pair 0 / ASID 0 but are invalid
    lookup(40'h123, 8'h00, 0, "R1");
    idle(2);

    // entry 0: 4 KB pair, ASID 5, even V+D, odd V only
    write_entry(0, 14'h0, 40'h20_0000 | 40'h5, (32'h123 << 6) | 32'h6, (32'h456 << 6) | 32'h2);
    lookup(40'h20_0ABC, 8'h05, 0, "R6");   // even hit level 2
    lookup(40'h20_1123, 8'h05, 0, "R5");   // odd hit level 1
    lookup(40'h20_1123, 8'h05, 1, "R9");   // write clean -> modify
    lookup(40'h20_0ABC, 8'h05, 1, "R6");   // write dirty -> hit
    lookup(40'h20_0ABC, 8'h06, 0, "R7");   // ASID mismatch read
    lookup(40'h20_0ABC, 8'h06, 1, "R7");   // ASID mismatch write
    lookup(40'h20_2000, 8'h05, 0, "R4");   // next pair -> miss
    idle(2);

    // entry 1: 16 KB pair, global, even invalid
    write_entry(1, 14'h3, 40'h40_0000 | 40'h1000 | 40'h9, (32'h777 << 6), (32'h888 << 6) | 32'h6);
    lookup(40'h40_1234, 8'h33, 0, "R8");
    lookup(40'h40_1234, 8'h33, 1, "R8");
    lookup(40'h40_6345, 8'h44, 1, "R4");   // global odd hit, 14-bit offset
    lookup(40'h40_7FFF, 8'h09, 0, "R3");

    // entry 2: 64 MB pair, ASID 0x22, odd D without V
    write_entry(2, 14'h3FFF, 40'h3_0000_0000 | 40'h22, (32'h40000 << 6) | 32'h6, (32'h80000 << 6) | 32'h4);
    lookup(40'h3_0123_4567, 8'h22, 0, "R3");
    lookup(40'h3_0523_4567, 8'h22, 1, "R8");
    // entry 3: undefined field falls back to 4 KB
    write_entry(3, 14'h1, 40'h50_0000 | 40'h5, (32'h999 << 6) | 32'h2, (32'hAAA << 6) | 32'h6);
    lookup(40'h50_1010, 8'h05, 0, "R3");
    lookup(40'h50_2010, 8'h05, 0, "R3");
    // entries 5 and 7 overlap: lowest index wins
    write_entry(5, 14'h0, 40'h60_0000 | 40'h5, (32'h111 << 6) | 32'h6, 32'h0);
    write_entry(7, 14'h0, 40'h60_0000 | 40'h5, (32'h222 << 6) | 32'h6, 32'h0);
    lookup(40'h60_0040, 8'h05, 0, "R11");
    write_entry(5, 14'h0, 40'h70_0000 | 40'h5, (32'h111 << 6) | 32'h6, 32'h0);
    lookup(40'h60_0040, 8'h05, 0, "R2");
    lookup(40'h70_0040, 8'h05, 0, "R2");
    write_entry(47, 14'h0, 40'h80_0000 | 40'h5, (32'h333 << 6) | 32'h6, (32'h334 << 6) | 32'h6);
    lookup(40'h80_1FFF, 8'h05, 1, "R2");
    idle(1);
    // R12: one response per request, none while idle
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid === 0, "R12", $sformatf("rsp_valid=%0d exp 0", rsp_valid));
    end

    // mixed traffic, back to back
    bases[0] = 40'h20_0000; bases[1] = 40'h40_0000; bases[2] = 40'h3_0000_0000; bases[3] = 40'h50_0000;
    bases[4] = 40'h60_0000; bases[5] = 40'h70_0000; bases[6] = 40'h80_0000;    bases[7] = 40'h90_0000;
    asids[0] = 8'h05; asids[1] = 8'h09; asids[2] = 8'h22; asids[3] = 8'h06;
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lookup(bases[lfsr[2:0]] + VA_W'(lfsr ^ 16'h5A5A) + VA_W'(lfsr[12:11]) * 40'h400_0000,
             asids[lfsr[4:3]], lfsr[7], "R10");
    end
    idle(3);
    chk(q.size() == 0, "R12", $sformatf("pending=%0d exp 0", q.size()));
    finish_run();
  end
endmodule